// File: doc/BRIEF.md
# Mailbox Command Sequencer

This block runs one complete mailbox exchange with a remote controller on behalf of a single requester. A start pulse carries a command index. The sequencer first checks that the index is supported. It then writes a five-word request into the remote message RAM and rings the doorbell. Next it polls the result mailbox at a fixed spacing until that mailbox reads nonzero or a bound on attempts runs out.

On a reply, it reads back the five response words. In every case where a request was sent, it writes zero into the result mailbox. The sequencer then validates the response checksum and folds the posted code into a small status index. All remote accesses go through a simple 32-bit single-transfer register bus. Each transfer is held until the responder acknowledges it.

Status index encoding: 0 means success. Any other value is the 1-based position of the lowest set bit of the effective result code, taken after bit 31 is cleared. A response with a bad checksum therefore yields 3. An exhausted poll loop yields 5. A rejected command index yields 1.

Top module: `mbx_cmd_sequencer`

## Requirements
- R1: After reset, busy_o, done_o and bus_req_o are low. Whenever busy_o is low, no bus transfer is requested.
- R2: An accepted command first writes its five request words in slot order to MSG_BASE, MSG_BASE+4, ..., MSG_BASE+16. The words are: header 1; command word 1 for index 0 and 2 for indices 1 and 2; argument count 1; argument 2 for index 2 and 1 otherwise; and a checksum equal to the 32-bit sum of the first four. Only after these five writes is the value 1 written to DOORBELL_ADDR.
- R3: After the doorbell, RESULT_ADDR is read until it returns nonzero. This happens at most POLL_MAX times. Each read that returns zero is followed by exactly POLL_GAP idle cycles before the next read request is raised.
- R4: When all POLL_MAX reads return zero, the status is 5 (timeout, error flag bit 4). No message RAM word is read, and the response output is all zero.
- R5: After polling ends, whether by reply or by timeout, exactly one write of 0 to RESULT_ADDR takes place before done_o.
- R6: If response word 4 differs from the 32-bit sum of words 0 to 3, the status is 3, whatever code was posted.
- R7: With a valid checksum, a posted code of 0x1 gives status 0. Any other code gives the 1-based position of its lowest set bit after bit 31 is cleared. If no bit remains, the status is 0 (for example, 0x80000008 gives 4, 0x00000C00 gives 11, and 0x80000000 gives 0).
- R8: A start with a command index of 3 or more produces done_o in the next cycle with status 1. No bus request is made.
- R9: busy_o stays high from an accepted start through the single-cycle done_o pulse. Start pulses while busy_o is high are ignored.
- R10: After a reply, resp_o holds the five words read from MSG_BASE upward, with word 0 in bits 31:0.
- R11: While a bus request waits for its acknowledge, its address, write enable and write data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse for one command |
| cmd_i | input | CMD_W | Command index sampled with start_i |
| busy_o | output | 1 | A command is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 5 | Status index, valid with done_o |
| resp_o | output | 160 | Five response words, word 0 lowest |
| bus_req_o | output | 1 | Bus transfer request |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | ADDR_W | Byte address of the transfer |
| bus_wdata_o | output | 32 | Write data |
| bus_ack_i | input | 1 | Transfer acknowledge, read data valid |
| bus_rdata_i | input | 32 | Read data |

## Verification
The bench targets the checksum override both with a success code and with an error code. A design that trusts the posted code would report 0 or 2 there instead of 3. It drives a reply on the very last allowed poll, where an off-by-one bound would time out early, and a reply that never arrives. In the no-reply case, it checks that no message RAM read happens and that the mailbox is still cleared. It also covers the codes 0x80000000 and 0x00000C00, which expose a lowest-set-bit search that starts from the wrong end or forgets to drop the error flag. Finally it fires an out-of-range start while a command is running, which a design that does not block starts would answer with an extra done.

// File: rtl/mbx_seq_pkg.sv
package mbx_seq_pkg;

  localparam int WORD_W    = 32;
  localparam int MSG_WORDS = 5;
  localparam int NUM_CMDS  = 3;
  localparam int STAT_W    = 5;

  localparam logic [WORD_W-1:0] ERR_FLAG  = 32'h8000_0000;
  localparam logic [WORD_W-1:0] CODE_OK   = 32'h0000_0001;
  localparam logic [WORD_W-1:0] CODE_CSUM = ERR_FLAG | 32'h0000_0004;
  localparam logic [WORD_W-1:0] CODE_TMO  = ERR_FLAG | 32'h0000_0010;
  localparam logic [STAT_W-1:0] STAT_REJECT = 5'd1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PUT, ST_RING, ST_POLL, ST_GAP, ST_GET, ST_CLEAR, ST_DONE
  } seq_state_e;

  // request word for a command at a given slot; slot 4 is the sum of 0..3
  function automatic logic [WORD_W-1:0] req_word(input int unsigned cmd,
                                                 input int unsigned slot);
    logic [WORD_W-1:0] hdr, opc, cnt, arg;
    hdr = 32'd1;
    opc = (cmd == 0) ? 32'd1 : 32'd2;
    cnt = 32'd1;
    arg = (cmd == 2) ? 32'd2 : 32'd1;
    case (slot)
      0:       return hdr;
      1:       return opc;
      2:       return cnt;
      3:       return arg;
      default: return hdr + opc + cnt + arg;
    endcase
  endfunction

  // 1-based index of the lowest set bit among bits 30..0, zero if none
  function automatic logic [STAT_W-1:0] first_one_pos(input logic [WORD_W-1:0] v);
    logic [STAT_W-1:0] p;
    p = '0;
    for (int i = WORD_W - 2; i >= 0; i--) begin
      if (v[i]) p = STAT_W'(i + 1);
    end
    return p;
  endfunction

  function automatic logic [WORD_W-1:0] sum_head(
      input logic [MSG_WORDS-1:0][WORD_W-1:0] w);
    logic [WORD_W-1:0] s;
    s = '0;
    for (int i = 0; i < MSG_WORDS - 1; i++) s = s + w[i];
    return s;
  endfunction

endpackage

// File: rtl/mbx_poll_timer.sv
module mbx_poll_timer #(
  parameter int POLL_MAX = 200000,
  parameter int POLL_GAP = 500,
  localparam int TRY_W   = $clog2(POLL_MAX + 1),
  localparam int GAP_W   = (POLL_GAP > 1) ? $clog2(POLL_GAP) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             miss_i,
  input  logic             in_gap_i,
  output logic             last_try_o,
  output logic             gap_done_o,
  output logic [TRY_W-1:0] tries_o
);

  logic [GAP_W-1:0] gap_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !in_gap_i) gap_cnt <= '0;
    else                     gap_cnt <= gap_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) tries_o <= '0;
    else if (miss_i)     tries_o <= tries_o + 1'b1;
  end

  assign gap_done_o = in_gap_i && (gap_cnt == GAP_W'(POLL_GAP - 1));
  assign last_try_o = (tries_o == TRY_W'(POLL_MAX - 1));

endmodule

// File: rtl/mbx_status_calc.sv
module mbx_status_calc
  import mbx_seq_pkg::*;
(
  input  logic                               reject_i,
  input  logic                               timed_i,
  input  logic [WORD_W-1:0]                  code_i,
  input  logic [MSG_WORDS-1:0][WORD_W-1:0]   words_i,
  output logic                               csum_bad_o,
  output logic [STAT_W-1:0]                  status_o
);

  logic [WORD_W-1:0] eff_code;

  assign csum_bad_o = (sum_head(words_i) != words_i[MSG_WORDS-1]);
  assign eff_code   = csum_bad_o ? CODE_CSUM : code_i;

  always_comb begin
    if (reject_i)              status_o = STAT_REJECT;
    else if (timed_i)          status_o = first_one_pos(CODE_TMO & ~ERR_FLAG);
    else if (eff_code == CODE_OK) status_o = '0;
    else                       status_o = first_one_pos(eff_code & ~ERR_FLAG);
  end

endmodule

// File: rtl/mbx_cmd_sequencer.sv
module mbx_cmd_sequencer
  import mbx_seq_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int CMD_W    = 2,
  parameter int POLL_MAX = 200000,
  parameter int POLL_GAP = 500,
  parameter logic [ADDR_W-1:0] MSG_BASE      = 'h100,
  parameter logic [ADDR_W-1:0] DOORBELL_ADDR = 'h10,
  parameter logic [ADDR_W-1:0] RESULT_ADDR   = 'h14
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start_i,
  input  logic [CMD_W-1:0]            cmd_i,
  output logic                        busy_o,
  output logic                        done_o,
  output logic [STAT_W-1:0]           status_o,
  output logic [MSG_WORDS*WORD_W-1:0] resp_o,
  output logic                        bus_req_o,
  output logic                        bus_we_o,
  output logic [ADDR_W-1:0]           bus_addr_o,
  output logic [WORD_W-1:0]           bus_wdata_o,
  input  logic                        bus_ack_i,
  input  logic [WORD_W-1:0]           bus_rdata_i
);

  localparam int IDX_W = $clog2(MSG_WORDS);
  localparam int TRY_W = $clog2(POLL_MAX + 1);
  localparam logic [CMD_W:0]   CMD_LIMIT = (CMD_W + 1)'(NUM_CMDS);
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(MSG_WORDS - 1);

  seq_state_e                       st;
  logic [IDX_W-1:0]                 idx;
  logic [CMD_W-1:0]                 cmd_q;
  logic [WORD_W-1:0]                code_q;
  logic                             timed_q;
  logic                             reject_q;
  logic [MSG_WORDS-1:0][WORD_W-1:0] resp_q;

  // named events for the checker
  logic accept_evt, start_evt, reject_evt, xfer_done;
  logic poll_miss, last_try, gap_done, csum_bad;
  logic [TRY_W-1:0] tries;

  assign xfer_done  = bus_req_o && bus_ack_i;
  assign accept_evt = (st == ST_IDLE) && start_i;
  assign start_evt  = accept_evt && ({1'b0, cmd_i} < CMD_LIMIT);
  assign reject_evt = accept_evt && !({1'b0, cmd_i} < CMD_LIMIT);
  assign poll_miss  = (st == ST_POLL) && xfer_done && (bus_rdata_i == '0);

  mbx_poll_timer #(
    .POLL_MAX (POLL_MAX),
    .POLL_GAP (POLL_GAP)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      ((st == ST_RING) && xfer_done),
    .miss_i     (poll_miss),
    .in_gap_i   (st == ST_GAP),
    .last_try_o (last_try),
    .gap_done_o (gap_done),
    .tries_o    (tries)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      idx      <= '0;
      cmd_q    <= '0;
      code_q   <= '0;
      timed_q  <= 1'b0;
      reject_q <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (accept_evt) begin
            idx      <= '0;
            cmd_q    <= cmd_i;
            code_q   <= '0;
            timed_q  <= 1'b0;
            reject_q <= reject_evt;
            st       <= reject_evt ? ST_DONE : ST_PUT;
          end
        end
        ST_PUT: begin
          if (xfer_done) begin
            if (idx == LAST_IDX) begin
              idx <= '0;
              st  <= ST_RING;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        ST_RING: if (xfer_done) st <= ST_POLL;
        ST_POLL: begin
          if (xfer_done) begin
            if (bus_rdata_i != '0) begin
              code_q <= bus_rdata_i;
              idx    <= '0;
              st     <= ST_GET;
            end else if (last_try) begin
              timed_q <= 1'b1;
              st      <= ST_CLEAR;
            end else begin
              st <= ST_GAP;
            end
          end
        end
        ST_GAP: if (gap_done) st <= ST_POLL;
        ST_GET: begin
          if (xfer_done) begin
            if (idx == LAST_IDX) st <= ST_CLEAR;
            else                 idx <= idx + 1'b1;
          end
        end
        ST_CLEAR: if (xfer_done) st <= ST_DONE;
        default:  st <= ST_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < MSG_WORDS; g++) begin : g_resp
    always_ff @(posedge clk) begin
      if (!rst_n || accept_evt) resp_q[g] <= '0;
      else if ((st == ST_GET) && xfer_done && (idx == IDX_W'(g)))
        resp_q[g] <= bus_rdata_i;
    end
  end

  always_comb begin
    bus_req_o   = 1'b0;
    bus_we_o    = 1'b0;
    bus_addr_o  = '0;
    bus_wdata_o = '0;
    case (st)
      ST_PUT: begin
        bus_req_o   = 1'b1;
        bus_we_o    = 1'b1;
        bus_addr_o  = MSG_BASE + ADDR_W'({idx, 2'b00});
        bus_wdata_o = req_word(int'(cmd_q), int'(idx));
      end
      ST_RING: begin
        bus_req_o   = 1'b1;
        bus_we_o    = 1'b1;
        bus_addr_o  = DOORBELL_ADDR;
        bus_wdata_o = 32'd1;
      end
      ST_POLL: begin
        bus_req_o  = 1'b1;
        bus_addr_o = RESULT_ADDR;
      end
      ST_GET: begin
        bus_req_o  = 1'b1;
        bus_addr_o = MSG_BASE + ADDR_W'({idx, 2'b00});
      end
      ST_CLEAR: begin
        bus_req_o  = 1'b1;
        bus_we_o   = 1'b1;
        bus_addr_o = RESULT_ADDR;
      end
      default: ;
    endcase
  end

  mbx_status_calc u_stat (
    .reject_i   (reject_q),
    .timed_i    (timed_q),
    .code_i     (code_q),
    .words_i    (resp_q),
    .csum_bad_o (csum_bad),
    .status_o   (status_o)
  );

  assign busy_o = (st != ST_IDLE);
  assign done_o = (st == ST_DONE);
  assign resp_o = resp_q;

endmodule

// File: rtl/mbx_seq_checker.sv
module mbx_seq_checker #(
  parameter int ADDR_W   = 12,
  parameter int POLL_MAX = 200000,
  localparam int TRY_W   = $clog2(POLL_MAX + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy_o,
  input logic              done_o,
  input logic [4:0]        status_o,
  input logic              bus_req_o,
  input logic              bus_we_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic [31:0]       bus_wdata_o,
  input logic              bus_ack_i,
  input logic              reject_evt,
  input logic              timed_q,
  input logic              csum_bad,
  input logic [TRY_W-1:0]  tries
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !bus_req_o);

  p_try_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tries <= TRY_W'(POLL_MAX));

  p_timeout_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && timed_q) |-> (status_o == 5'd5));

  p_csum_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !timed_q && csum_bad && status_o != 5'd1) |-> (status_o == 5'd3));

  p_reject_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reject_evt |=> (done_o && !bus_req_o && status_o == 5'd1));

  p_done_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> busy_o);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_o && !bus_ack_i) |=> (bus_req_o && $stable(bus_addr_o) &&
                                   $stable(bus_we_o) && $stable(bus_wdata_o)));

endmodule

bind mbx_cmd_sequencer mbx_seq_checker #(
  .ADDR_W   (ADDR_W),
  .POLL_MAX (POLL_MAX)
) u_seq_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .status_o    (status_o),
  .bus_req_o   (bus_req_o),
  .bus_we_o    (bus_we_o),
  .bus_addr_o  (bus_addr_o),
  .bus_wdata_o (bus_wdata_o),
  .bus_ack_i   (bus_ack_i),
  .reject_evt  (reject_evt),
  .timed_q     (timed_q),
  .csum_bad    (csum_bad),
  .tries       (tries)
);

// File: tb/tb_mbx_cmd_sequencer.sv
module tb_mbx_cmd_sequencer;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 12;
  localparam int POLL_MAX   = 6;
  localparam int POLL_GAP   = 3;
  localparam int XFER_LAT   = 2;
  localparam logic [ADDR_W-1:0] A_MSG  = 'h100;
  localparam logic [ADDR_W-1:0] A_BELL = 'h10;
  localparam logic [ADDR_W-1:0] A_RES  = 'h14;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic [1:0]   cmd_i = '0;
  logic         busy_o, done_o;
  logic [4:0]   status_o;
  logic [159:0] resp_o;
  logic         bus_req_o, bus_we_o;
  logic [ADDR_W-1:0] bus_addr_o;
  logic [31:0]  bus_wdata_o;
  logic         bus_ack_i = 1'b0;
  logic [31:0]  bus_rdata_i = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbx_cmd_sequencer #(
    .ADDR_W (ADDR_W), .CMD_W (2), .POLL_MAX (POLL_MAX), .POLL_GAP (POLL_GAP)
  ) dut (
    .clk (clk), .rst_n (rst_n), .start_i (start_i), .cmd_i (cmd_i),
    .busy_o (busy_o), .done_o (done_o), .status_o (status_o), .resp_o (resp_o),
    .bus_req_o (bus_req_o), .bus_we_o (bus_we_o), .bus_addr_o (bus_addr_o),
    .bus_wdata_o (bus_wdata_o), .bus_ack_i (bus_ack_i), .bus_rdata_i (bus_rdata_i)
  );

  int total = 0, bad = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [159:0] act, input logic [159:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // responder model configuration
  logic [31:0] req_ram [5];
  logic [4:0][31:0] cfg_words;
  logic [31:0] cfg_code;
  bit          cfg_never;
  int          cfg_zero;
  int          zero_left;

  always @(posedge clk) begin
    if (!rst_n) begin
      bus_ack_i <= 1'b0;
    end else if (bus_req_o && !bus_ack_i) begin
      bus_ack_i <= 1'b1;
      if (bus_we_o) begin
        if (bus_addr_o >= A_MSG && bus_addr_o <= A_MSG + 16)
          req_ram[(bus_addr_o - A_MSG) >> 2] <= bus_wdata_o;
        else if (bus_addr_o == A_BELL && bus_wdata_o == 32'd1)
          zero_left = cfg_zero;
      end else if (bus_addr_o == A_RES) begin
        if (cfg_never || zero_left > 0) begin
          bus_rdata_i <= '0;
          zero_left = zero_left - 1;
        end else begin
          bus_rdata_i <= cfg_code;
        end
      end else if (bus_addr_o >= A_MSG && bus_addr_o <= A_MSG + 16) begin
        bus_rdata_i <= cfg_words[(bus_addr_o - A_MSG) >> 2];
      end else begin
        bus_rdata_i <= 32'hDEAD_BEEF;
      end
    end else begin
      bus_ack_i <= 1'b0;
    end
  end

  // bus monitor and per-command counters
  int cyc = 0;
  int n_put, n_ring, n_poll, n_get, n_clear, n_xfer;
  bit order_bad, gap_bad, clr_bad, pend;
  int last_poll, start_cyc, done_seen = 0;

  typedef struct {
    logic [4:0]   status;
    logic [159:0] resp;
    int           polls;
    int           gets;
    int           puts;
    int           latency;
    logic [4:0][31:0] req;
    string        tag;
  } exp_t;
  exp_t expq[$];

  task automatic clear_counts();
    n_put = 0; n_ring = 0; n_poll = 0; n_get = 0; n_clear = 0; n_xfer = 0;
    order_bad = 0; gap_bad = 0; clr_bad = 0; last_poll = -1;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (start_i && !busy_o) start_cyc = cyc;
    if (bus_req_o && !pend) begin
      pend = 1;
      if (!bus_we_o && bus_addr_o == A_RES) begin
        if (last_poll >= 0 && (cyc - last_poll) != POLL_GAP + XFER_LAT) gap_bad = 1;
        last_poll = cyc;
      end
    end
    if (bus_req_o && bus_ack_i) begin
      pend = 0;
      n_xfer++;
      if (bus_we_o && bus_addr_o == A_BELL) begin
        n_ring++;
        if (n_put != 5 || bus_wdata_o != 32'd1) order_bad = 1;
      end else if (bus_we_o && bus_addr_o == A_RES) begin
        n_clear++;
        if (bus_wdata_o != 0 || n_ring != 1) clr_bad = 1;
      end else if (bus_we_o) begin
        if (bus_addr_o != A_MSG + ADDR_W'(4 * n_put) || n_ring != 0) order_bad = 1;
        n_put++;
      end else if (bus_addr_o == A_RES) begin
        n_poll++;
      end else begin
        if (n_clear != 0) clr_bad = 1;
        n_get++;
      end
    end
    if (done_o) begin
      done_seen++;
      if (expq.size() == 0) begin
        check(0, "R9", "done without accepted start", 1, 0);
      end else begin
        exp_t e;
        e = expq.pop_front();
        check(status_o == e.status, e.tag, "status", status_o, e.status);
        check(resp_o == e.resp, "R10", "response words", resp_o, e.resp);
        check(n_poll == e.polls, "R3", "poll reads", n_poll, e.polls);
        check(n_get == e.gets, "R4", "message reads", n_get, e.gets);
        check(!gap_bad, "R3", "poll spacing", gap_bad, 0);
        if (e.latency >= 0) begin
          check(cyc - start_cyc == e.latency, "R8", "reject latency",
                cyc - start_cyc, e.latency);
          check(n_xfer == 0, "R8", "bus transfers on reject", n_xfer, 0);
        end else begin
          check(n_put == 5 && n_ring == 1 && !order_bad, "R2", "request order",
                {n_put, n_ring, 31'd0, order_bad}, {32'd5, 32'd1, 32'd0});
          check({req_ram[4], req_ram[3], req_ram[2], req_ram[1], req_ram[0]} == e.req,
                "R2", "request words",
                {req_ram[4], req_ram[3], req_ram[2], req_ram[1], req_ram[0]}, e.req);
          check(n_clear == 1 && !clr_bad, "R5", "mailbox clear",
                {n_clear, 31'd0, clr_bad}, {32'd1, 32'd0});
        end
      end
    end
  end

  function automatic logic [4:0] exp_status(bit never, logic [31:0] code,
                                            logic [4:0][31:0] w);
    logic [31:0] c;
    if (never) return 5'd5;
    c = (w[0] + w[1] + w[2] + w[3] != w[4]) ? 32'h8000_0004 : code;
    if (c == 32'd1) return 5'd0;
    c[31] = 1'b0;
    for (int i = 0; i < 31; i++) if (c[i]) return 5'(i + 1);
    return 5'd0;
  endfunction

  task automatic run_cmd(input int cmd, input int zero, input bit never,
                         input logic [31:0] code, input logic [4:0][31:0] w,
                         input string tag, input bit poke);
    exp_t e;
    int snap;
    logic [31:0] op, ar;
    e.tag = tag;
    op = (cmd == 0) ? 32'd1 : 32'd2;
    ar = (cmd == 2) ? 32'd2 : 32'd1;
    e.req = {32'd1 + op + 32'd1 + ar, ar, 32'd1, op, 32'd1};
    if (cmd >= 3) begin
      e.status = 5'd1; e.resp = '0; e.polls = 0; e.gets = 0; e.puts = 0;
      e.latency = 1;
    end else begin
      e.status  = exp_status(never, code, w);
      e.resp    = never ? '0 : w;
      e.polls   = never ? POLL_MAX : zero + 1;
      e.gets    = never ? 0 : 5;
      e.puts    = 5;
      e.latency = -1;
    end
    @(posedge clk); #1;
    cfg_never = never; cfg_zero = zero; cfg_code = code; cfg_words = w;
    clear_counts();
    expq.push_back(e);
    snap = done_seen;
    start_i = 1'b1; cmd_i = 2'(cmd);
    @(posedge clk); #1;
    start_i = 1'b0;
    if (poke) begin
      repeat (4) @(posedge clk);
      #1;
      check(busy_o == 1'b1, "R9", "busy during command", busy_o, 1);
      start_i = 1'b1; cmd_i = 2'd3;
      @(posedge clk); #1;
      start_i = 1'b0;
    end
    while (done_seen == snap) @(negedge clk);
    @(negedge clk);
    check(!busy_o && !done_o, "R9", "idle after done", {busy_o, done_o}, 0);
    repeat (3) @(posedge clk);
    check(expq.size() == 0, "R9", "no stray done", expq.size(), 0);
  endtask

  function automatic logic [4:0][31:0] mk(logic [31:0] a, logic [31:0] b,
                                         logic [31:0] c, logic [31:0] d, bit good);
    return {good ? a + b + c + d : a + b + c + d + 32'd7, d, c, b, a};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    check(0, "R1", "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cfg_never = 0; cfg_zero = 0; cfg_code = 0; cfg_words = '0; zero_left = 0;
    pend = 0; clear_counts();
    repeat (3) @(posedge clk);
    #1;
    check(!busy_o && !done_o && !bus_req_o, "R1", "reset outputs",
          {busy_o, done_o, bus_req_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    check(!busy_o && !bus_req_o, "R1", "idle after reset", {busy_o, bus_req_o}, 0);

    run_cmd(0, 0, 0, 32'h1, mk(32'h2, 32'h22, 32'h1, 32'hABCD, 1), "R7", 0);
    run_cmd(1, 2, 0, 32'h1, mk(32'h2, 32'h40, 32'h3, 32'h1234_5678, 1), "R3", 0);
    run_cmd(2, 1, 0, 32'h8000_0008, mk(32'h2, 32'h9, 32'h0, 32'h5, 1), "R7", 0);
    run_cmd(0, 0, 0, 32'h1, mk(32'h2, 32'h1, 32'h1, 32'h77, 0), "R6", 0);
    run_cmd(1, 0, 0, 32'h8000_0002, mk(32'h2, 32'h5, 32'h6, 32'h8, 0), "R6", 0);
    run_cmd(2, 0, 1, 32'h1, mk(32'h2, 32'h1, 32'h1, 32'h1, 1), "R4", 0);
    run_cmd(1, POLL_MAX - 1, 0, 32'h1, mk(32'h2, 32'h3, 32'h4, 32'h5, 1), "R3", 0);
    run_cmd(3, 0, 0, 32'h1, mk(32'h1, 32'h1, 32'h1, 32'h1, 1), "R8", 0);
    run_cmd(0, 0, 0, 32'h8000_0000, mk(32'h2, 32'h0, 32'h1, 32'h9, 1), "R7", 0);
    run_cmd(2, 0, 0, 32'h0000_0C00, mk(32'hF, 32'hE, 32'hD, 32'hC, 1), "R7", 0);
    run_cmd(1, 3, 0, 32'h1, mk(32'h2, 32'h11, 32'h22, 32'h33, 1), "R9", 1);
    run_cmd(0, 0, 0, 32'h1, mk(32'h2, 32'h1, 32'h1, 32'h1, 1), "R5", 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule